// File: doc/BRIEF.md
# Byte-Wide FPGA Configuration Streamer

This block loads a slave FPGA that takes its configuration one byte at a time on a parallel write port. On a start pulse it holds the active-low program line low for a set number of cycles and then releases it. It then waits for the slave's active-low init line to go high, with a timeout. Once init is high it writes a fixed header, then a sequence of framed records, then four startup bytes. Last, it samples the slave's done line and reports success or an error code.

Raw configuration data arrives on a byte-wide valid/ready stream. The block adds every framing byte itself. Each record is a preamble, a payload of a parameterised number of bytes (21 by default), a check byte and five padding bytes. Back-pressure rules:
- The block raises `pld_ready` only in a cycle where it can write a payload byte.
- A byte is taken on a clock edge where `pld_valid` and `pld_ready` are both high.
- While the source holds `pld_valid` low, the block stalls without writing anything.
- The source marks its final byte with `pld_last`. The frame that holds that byte is completed with FF fill, and then the startup bytes follow.

While the header and records are being written, the block stops at once and reports an abort if init falls or done rises. Every byte write is a one-cycle strobe, and a parameterised number of idle cycles separates any two strobes.

Top module: `fpga_cfg_streamer`

## Requirements
- R1: After reset, `cfg_prog_n` is 1 and `cfg_wr`, `pld_ready`, `busy`, `cfg_ok` and `cfg_err` are all 0.
- R2: A `start` pulse, accepted when the block is idle, finished or in error, drives `cfg_prog_n` low for exactly PROG_CYC cycles, then high. No strobe occurs while it is low.
- R3: No byte is strobed until `cfg_init_n` has been seen high after program is released.
- R4: If `cfg_init_n` stays low for INIT_TIMEOUT cycles after release, the block enters error with `err_code` = 1 and writes nothing.
- R5: The header is written as the bytes FF, FF, FF, 4F, 80, AF, 9B, 4B in that order.
- R6: Each frame is written as 4F, then FRAME_BYTES payload bytes, then 4B, FF, 4B, FF, FF, FF.
- R7: Payload bytes are taken only on edges where `pld_valid` and `pld_ready` are both high. They appear on `cfg_data` in arrival order, and the block stalls while `pld_valid` is low.
- R8: If `pld_last` arrives before the payload slots of the current frame are full, the remaining slots are written as FF and `pld_ready` stays low.
- R9: After the frame that holds the last payload byte, four FF startup bytes are written.
- R10: After the startup bytes, if `cfg_done` is high the block reports `cfg_ok`. Otherwise it reports `cfg_err` with `err_code` = 3.
- R11: If `cfg_init_n` is low or `cfg_done` is high during the header or the frames, the block writes no further byte and reports `cfg_err` with `err_code` = 2.
- R12: Each strobe lasts one cycle, and at least WR_GAP idle cycles separate any two strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration run |
| pld_data | input | 8 | Payload byte |
| pld_valid | input | 1 | Payload byte valid |
| pld_last | input | 1 | Marks the final payload byte |
| pld_ready | output | 1 | Block takes the payload byte this cycle |
| cfg_init_n | input | 1 | Slave init line, low = not ready / fault |
| cfg_done | input | 1 | Slave done line |
| cfg_prog_n | output | 1 | Slave program line, low = reset |
| cfg_wr | output | 1 | One-cycle byte write strobe |
| cfg_data | output | 8 | Byte being written |
| busy | output | 1 | Run in progress |
| cfg_ok | output | 1 | Run finished with done high |
| cfg_err | output | 1 | Run ended in error |
| err_code | output | 2 | 0 none, 1 init timeout, 2 abort, 3 done missing |

## Verification
The bench builds the block with PROG_CYC = 5, INIT_TIMEOUT = 40 and WR_GAP = 2, and keeps the default FRAME_BYTES of 21. With these values the program pulse width can be measured exactly and the init timeout expires within a few dozen cycles. Every strobe has a two-cycle spacing, so an abort raised just after a strobe must block the next write. Runs use payload lengths of 1, 21, 30 and 42 bytes. They cover a single full frame, a partly filled second frame, two full frames, and a stall pattern on the source.

// File: rtl/fpcfg_pkg.sv
`timescale 1ns/1ps
package fpcfg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PROG, ST_WAIT, ST_HDR, ST_FRM, ST_BOOT, ST_CHK, ST_OK, ST_ERR
  } st_t;

  typedef enum logic [1:0] {
    E_NONE    = 2'd0,
    E_TIMEOUT = 2'd1,
    E_ABORT   = 2'd2,
    E_NODONE  = 2'd3
  } err_t;

  typedef enum logic [1:0] { SRC_HDR, SRC_FRM, SRC_BOOT } src_t;

  localparam int HDR_LEN  = 8;
  localparam int BOOT_LEN = 4;
  localparam int TAIL_LEN = 6;
  localparam logic [7:0] PRE_BYTE  = 8'h4F;
  localparam logic [7:0] FILL_BYTE = 8'hFF;

  function automatic logic [7:0] hdr_byte(input int unsigned i);
    case (i)
      3:       return 8'h4F;
      4:       return 8'h80;
      5:       return 8'hAF;
      6:       return 8'h9B;
      7:       return 8'h4B;
      default: return FILL_BYTE;
    endcase
  endfunction

  function automatic logic [7:0] tail_byte(input int unsigned i);
    case (i)
      0, 2:    return 8'h4B;
      default: return FILL_BYTE;
    endcase
  endfunction

endpackage

// File: rtl/fpcfg_timer.sv
`timescale 1ns/1ps
module fpcfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fpcfg_pacer.sv
`timescale 1ns/1ps
module fpcfg_pacer #(
  parameter int GAP = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic free
);
  generate
    if (GAP == 0) begin : g_nogap
      assign free = 1'b1;
    end else begin : g_gap
      localparam int GW = $clog2(GAP + 1);
      logic [GW-1:0] left;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           left <= '0;
        else if (fire)        left <= GW'(GAP);
        else if (left != '0)  left <= left - 1'b1;
      end
      assign free = (left == '0);
    end
  endgenerate

  AST_PACE_FIRE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> free) else $error("write issued inside gap"); // R12
endmodule

// File: rtl/fpcfg_bytesel.sv
`timescale 1ns/1ps
module fpcfg_bytesel
  import fpcfg_pkg::*;
#(
  parameter int FRAME_BYTES = 21,
  parameter int IDX_W       = 5
) (
  input  src_t             src,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       pay_byte,
  input  logic             pad,
  output logic [7:0]       byte_o
);
  always_comb begin
    case (src)
      SRC_HDR: byte_o = hdr_byte(int'(idx));
      SRC_FRM: begin
        if (idx == '0)
          byte_o = PRE_BYTE;
        else if (int'(idx) <= FRAME_BYTES)
          byte_o = pad ? FILL_BYTE : pay_byte;
        else
          byte_o = tail_byte(int'(idx) - FRAME_BYTES - 1);
      end
      default: byte_o = FILL_BYTE;
    endcase
  end
endmodule

// File: rtl/fpga_cfg_streamer.sv
`timescale 1ns/1ps
module fpga_cfg_streamer
  import fpcfg_pkg::*;
#(
  parameter int FRAME_BYTES  = 21,
  parameter int PROG_CYC     = 50,
  parameter int INIT_TIMEOUT = 100000,
  parameter int WR_GAP       = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] pld_data,
  input  logic       pld_valid,
  input  logic       pld_last,
  output logic       pld_ready,
  input  logic       cfg_init_n,
  input  logic       cfg_done,
  output logic       cfg_prog_n,
  output logic       cfg_wr,
  output logic [7:0] cfg_data,
  output logic       busy,
  output logic       cfg_ok,
  output logic       cfg_err,
  output logic [1:0] err_code
);
  localparam int FRAME_LEN = FRAME_BYTES + 1 + TAIL_LEN;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int TMAX      = (PROG_CYC > INIT_TIMEOUT) ? PROG_CYC : INIT_TIMEOUT;
  localparam int TW        = $clog2(TMAX + 1);

  st_t              st, st_nx;
  err_t             err_q, err_nx;
  logic [IDX_W-1:0] idx, idx_nx;
  logic             ended, ended_nx;
  logic             issue, ready, free, bad;
  src_t             src;
  logic [7:0]       sel_byte;
  logic [TW-1:0]    tcnt;
  logic             wr_q;
  logic [7:0]       data_q;
  logic             pay_slot;

  fpcfg_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(st_nx != st), .cnt(tcnt)
  );

  fpcfg_pacer #(.GAP(WR_GAP)) u_pacer (
    .clk(clk), .rst_n(rst_n), .fire(issue), .free(free)
  );

  fpcfg_bytesel #(.FRAME_BYTES(FRAME_BYTES), .IDX_W(IDX_W)) u_sel (
    .src(src), .idx(idx), .pay_byte(pld_data), .pad(ended), .byte_o(sel_byte)
  );

  assign bad      = !cfg_init_n || cfg_done;
  assign pay_slot = (idx != '0) && (int'(idx) <= FRAME_BYTES);

  always_comb begin
    st_nx    = st;
    err_nx   = err_q;
    idx_nx   = idx;
    ended_nx = ended;
    issue    = 1'b0;
    ready    = 1'b0;
    src      = SRC_BOOT;
    case (st)
      ST_IDLE, ST_OK, ST_ERR: begin
        if (start) begin
          st_nx    = ST_PROG;
          err_nx   = E_NONE;
          idx_nx   = '0;
          ended_nx = 1'b0;
        end
      end
      ST_PROG: begin
        if (tcnt == TW'(PROG_CYC - 1)) st_nx = ST_WAIT;
      end
      ST_WAIT: begin
        if (cfg_init_n) st_nx = ST_HDR;
        else if (tcnt == TW'(INIT_TIMEOUT - 1)) begin
          st_nx  = ST_ERR;
          err_nx = E_TIMEOUT;
        end
      end
      ST_HDR: begin
        src = SRC_HDR;
        if (bad) begin
          st_nx  = ST_ERR;
          err_nx = E_ABORT;
        end else if (free) begin
          issue = 1'b1;
          if (idx == IDX_W'(HDR_LEN - 1)) begin
            idx_nx = '0;
            st_nx  = ST_FRM;
          end else begin
            idx_nx = idx + 1'b1;
          end
        end
      end
      ST_FRM: begin
        src = SRC_FRM;
        if (bad) begin
          st_nx  = ST_ERR;
          err_nx = E_ABORT;
        end else if (free) begin
          if (pay_slot && !ended) begin
            ready = 1'b1;
            if (pld_valid) begin
              issue  = 1'b1;
              idx_nx = idx + 1'b1;
              if (pld_last) ended_nx = 1'b1;
            end
          end else begin
            issue = 1'b1;
            if (idx == IDX_W'(FRAME_LEN - 1)) begin
              idx_nx = '0;
              if (ended) st_nx = ST_BOOT;
            end else begin
              idx_nx = idx + 1'b1;
            end
          end
        end
      end
      ST_BOOT: begin
        if (free) begin
          issue = 1'b1;
          if (idx == IDX_W'(BOOT_LEN - 1)) begin
            idx_nx = '0;
            st_nx  = ST_CHK;
          end else begin
            idx_nx = idx + 1'b1;
          end
        end
      end
      ST_CHK: begin
        if (free) begin
          if (cfg_done) st_nx = ST_OK;
          else begin
            st_nx  = ST_ERR;
            err_nx = E_NODONE;
          end
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      err_q  <= E_NONE;
      idx    <= '0;
      ended  <= 1'b0;
      wr_q   <= 1'b0;
      data_q <= 8'h00;
    end else begin
      st    <= st_nx;
      err_q <= err_nx;
      idx   <= idx_nx;
      ended <= ended_nx;
      wr_q  <= issue;
      if (issue) data_q <= sel_byte;
    end
  end

  assign pld_ready  = ready;
  assign cfg_wr     = wr_q;
  assign cfg_data   = data_q;
  assign cfg_prog_n = (st != ST_PROG);
  assign busy       = !(st == ST_IDLE || st == ST_OK || st == ST_ERR);
  assign cfg_ok     = (st == ST_OK);
  assign cfg_err    = (st == ST_ERR);
  assign err_code   = err_q;

  logic [7:0] since_wr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_wr <= 8'hFF;
    else if (cfg_wr)            since_wr <= 8'h00;
    else if (since_wr != 8'hFF) since_wr <= since_wr + 8'd1;
  end

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |-> (since_wr >= 8'(WR_GAP))) else $error("strobe gap too short"); // R12
  AST_PROG_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> !cfg_wr) else $error("write during program pulse"); // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!cfg_wr && !pld_ready)) else $error("activity in error"); // R11
  AST_READY_STATUS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    pld_ready |-> (cfg_init_n && !cfg_done)) else $error("ready with bad status"); // R11
  AST_OK_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ok) |-> $past(cfg_done)) else $error("ok without done"); // R10
  AST_TIMEOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cfg_err) && err_code == E_TIMEOUT) |-> !$past(cfg_init_n))
    else $error("timeout with init high"); // R4
endmodule

// File: tb/fpga_cfg_streamer_tb_top.sv
`timescale 1ns/1ps
module fpga_cfg_streamer_tb_top;
  localparam int FB   = 21;
  localparam int PROG = 5;
  localparam int TOUT = 40;
  localparam int GAP  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] pld_data = 8'h00;
  logic pld_valid = 1'b0;
  logic pld_last = 1'b0;
  logic pld_ready;
  logic cfg_init_n = 1'b1;
  logic cfg_done = 1'b0;
  logic cfg_prog_n, cfg_wr, busy, cfg_ok, cfg_err;
  logic [7:0] cfg_data;
  logic [1:0] err_code;

  always #2.5 clk = ~clk;

  fpga_cfg_streamer #(.FRAME_BYTES(FB), .PROG_CYC(PROG), .INIT_TIMEOUT(TOUT), .WR_GAP(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pld_data(pld_data), .pld_valid(pld_valid),
    .pld_last(pld_last), .pld_ready(pld_ready), .cfg_init_n(cfg_init_n), .cfg_done(cfg_done),
    .cfg_prog_n(cfg_prog_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data), .busy(busy),
    .cfg_ok(cfg_ok), .cfg_err(cfg_err), .err_code(err_code)
  );

  int n_checks = 0;
  int n_errors = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  int pay_n = 0, pay_idx = 0, stall_cnt = 0;
  bit stall_en = 0;
  bit init_never = 0, dropped = 0, done_good = 0;
  int init_delay = 0, icnt = 0;
  int abort_init_k = 0, abort_done_k = 0;
  int wr_count = 0, since = 0, low_cnt = 0, prog_w_last = 0;
  bit seen_any = 0;

  task automatic chk(input bit cond, input string tag, input int act, input int exp);
    n_checks++;
    if (!cond) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  function automatic logic [7:0] pbyte(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic push(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  // driver side of the scoreboard: expected byte stream from the requirements
  task automatic push_stream(input int n);
    int frames;
    logic [7:0] hdr[8] = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    logic [7:0] tl[6]  = '{8'h4B, 8'hFF, 8'h4B, 8'hFF, 8'hFF, 8'hFF};
    frames = (n + FB - 1) / FB;
    for (int i = 0; i < 8; i++) push(hdr[i], "R5 header");
    for (int f = 0; f < frames; f++) begin
      push(8'h4F, "R6 preamble");
      for (int k = 0; k < FB; k++) begin
        if (f * FB + k < n) push(pbyte(f * FB + k), "R7 payload");
        else                push(8'hFF, "R8 fill");
      end
      for (int i = 0; i < 6; i++) push(tl[i], "R6 tail");
    end
    for (int i = 0; i < 4; i++) push(8'hFF, "R9 startup");
  endtask

  // payload source
  initial begin
    forever begin
      @(negedge clk);
      pld_valid = (pay_idx < pay_n) && (!stall_en || ((stall_cnt % 4) != 1));
      stall_cnt++;
      pld_data = pbyte(pay_idx);
      pld_last = (pay_idx == pay_n - 1);
      #1;
      if (pld_valid && pld_ready) pay_idx++;
    end
  end

  // monitor plus slave model
  always @(negedge clk) begin
    if (rst_n) begin
      if (cfg_wr) begin
        wr_count++;
        if (seen_any) chk(since >= GAP, "R12 gap", since, GAP);
        since = 0;
        seen_any = 1;
        chk(cfg_init_n == 1'b1, "R3 write before init", 1, 0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected byte", int'(cfg_data), -1);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          n_checks++;
          if (cfg_data !== e) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", t, cfg_data, e);
          end
          if (exp_q.size() == 0 && done_good) cfg_done = 1'b1;
        end
      end else begin
        since++;
      end
      if (!cfg_prog_n) low_cnt++;
      else if (low_cnt != 0) begin
        prog_w_last = low_cnt;
        low_cnt = 0;
      end
      if (!cfg_prog_n) begin
        cfg_init_n = 1'b0;
        icnt = 0;
      end else if (!init_never && !cfg_init_n && !dropped) begin
        icnt++;
        if (icnt >= init_delay) cfg_init_n = 1'b1;
      end
      if (abort_init_k > 0 && wr_count >= abort_init_k) begin
        cfg_init_n = 1'b0;
        dropped = 1;
      end
      if (abort_done_k > 0 && wr_count >= abort_done_k) cfg_done = 1'b1;
    end
  end

  task automatic run_cfg(input int n, input int idelay, input bit never, input bit dgood,
                         input int ak_init, input int ak_done, input bit stall);
    @(posedge clk); #1;
    exp_q.delete(); tag_q.delete();
    pay_n = n; pay_idx = 0; stall_en = stall;
    init_delay = idelay; init_never = never; done_good = dgood;
    abort_init_k = ak_init; abort_done_k = ak_done;
    dropped = 0; cfg_done = 1'b0; cfg_init_n = 1'b1; wr_count = 0; seen_any = 0;
    if (!never) push_stream(n);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (!busy) break;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(cfg_prog_n == 1 && cfg_wr == 0 && pld_ready == 0 && busy == 0 && cfg_ok == 0 && cfg_err == 0,
        "R1 reset outputs", {cfg_prog_n, cfg_wr, pld_ready, busy, cfg_ok, cfg_err}, 6'b100000);
    #1 rst_n = 1'b1;

    // two full frames, stalling source
    run_cfg(42, 6, 0, 1, 0, 0, 1);
    chk(cfg_ok == 1 && cfg_err == 0, "R10 ok after done", cfg_ok, 1);
    chk(err_code == 0, "R10 code", err_code, 0);
    chk(exp_q.size() == 0, "R9 stream complete", exp_q.size(), 0);
    chk(pay_idx == 42, "R7 payload taken", pay_idx, 42);
    chk(prog_w_last == PROG, "R2 program pulse width", prog_w_last, PROG);

    // partial last frame
    run_cfg(30, 3, 0, 1, 0, 0, 0);
    chk(cfg_ok == 1, "R8 ok with fill", cfg_ok, 1);
    chk(exp_q.size() == 0, "R8 stream complete", exp_q.size(), 0);
    chk(pay_idx == 30, "R8 no extra payload", pay_idx, 30);

    // done never rises
    run_cfg(21, 2, 0, 0, 0, 0, 0);
    chk(cfg_err == 1 && cfg_ok == 0, "R10 error without done", cfg_err, 1);
    chk(err_code == 3, "R10 code", err_code, 3);
    chk(exp_q.size() == 0, "R6 one frame", exp_q.size(), 0);

    // init never rises
    run_cfg(21, 0, 1, 0, 0, 0, 0);
    chk(cfg_err == 1, "R4 timeout error", cfg_err, 1);
    chk(err_code == 1, "R4 code", err_code, 1);
    chk(wr_count == 0, "R4 no writes", wr_count, 0);

    // init drops mid-frame
    run_cfg(63, 4, 0, 0, 40, 0, 0);
    chk(cfg_err == 1 && err_code == 2, "R11 init abort code", err_code, 2);
    chk(wr_count == 40, "R11 writes stop on init", wr_count, 40);

    // done rises in header
    run_cfg(63, 4, 0, 0, 0, 3, 0);
    chk(cfg_err == 1 && err_code == 2, "R11 done abort code", err_code, 2);
    chk(wr_count == 3, "R11 writes stop on done", wr_count, 3);

    // restart after error, single byte payload
    run_cfg(1, 0, 0, 1, 0, 0, 0);
    chk(cfg_ok == 1 && err_code == 0, "R2 restart ok", cfg_ok, 1);
    chk(exp_q.size() == 0, "R8 single byte frame", exp_q.size(), 0);
    chk(prog_w_last == PROG, "R2 pulse on restart", prog_w_last, PROG);

    finish_up();
  end
endmodule